// File: doc/BRIEF.md
# Burst Byte-Mover Channel

This block is one channel of a byte-wide DMA engine. It moves bytes between a 24-bit primary address space (the A side) and a 256-register peripheral window (the B side, registers 0x2100 to 0x21FF). The B side is addressed through an 8-bit offset port. The surrounding register file supplies the configuration as static inputs. A one-cycle start pulse makes the channel latch that configuration and run the whole burst. Each byte is read from one side and written to the other.

Every byte takes a fixed eight-clock slot. The read is sampled at the end of the fourth clock. The write is held in a one-entry posted register and drains in the first clock of the following slot, or in the first clock of the trailing overhead. Two kinds of access are suppressed but keep their bus time: A-side accesses that would land on the system's own control-register pages, and B-side accesses to the work-RAM data port (offset 0x80) whose A address also lies in work RAM. A suppressed read yields zero. An abort input ends the burst early at a byte boundary.

Top module: `bdma_channel`

## Requirements
- R1: While rst_n is low, and in the cycle after it, busy is low and none of a_rd, a_wr, b_rd, b_wr is asserted. No strobe ever fires while busy is low.
- R2: A start pulse sampled while busy is low raises busy on the next cycle. For a burst of N bytes, busy then stays high for exactly 16+8N cycles: 8 setup, 8 per byte, 8 trailing. A start pulse or a configuration change while busy has no effect on the running burst.
- R3: Counting the cycle after the start edge as cycle 1, byte k (from 0) has its read strobe in cycle 12+8k. Its write strobe comes in cycle 17+8k. At most one strobe is asserted per cycle.
- R4: With cfg_dir=0 the byte is read from the A side and written to the B side. With cfg_dir=1 it is read from the B side and written to the A side. The written data equals the data read.
- R5: The B offset of byte k is cfg_boff plus an adjustment, taken modulo 256, where i = k mod 4. The adjustment is i[0] for modes 1 and 5, i[1] for modes 3 and 7, i for mode 4, and 0 for modes 0, 2 and 6.
- R6: The A address is {cfg_bank, offset}. With cfg_fixed=1 the offset holds. Otherwise it goes up by 1 per byte, or down by 1 per byte when cfg_reverse=1, wrapping in 16 bits. The bank never changes.
- R7: cfg_count gives the number of bytes. A value of 0 moves 2^CNT_W bytes.
- R8: An A access is suppressed when (a & 0x40FF00)==0x002100, (a & 0x40FE00)==0x004000, (a & 0x40FFE0)==0x004200 or (a & 0x40FF80)==0x004300. No strobe is issued for it, and a suppressed read supplies data 0x00.
- R9: A B access to offset 0x80 is suppressed, and a suppressed B read supplies 0x00, when the byte's A address has bits [23:17]=0x3F or satisfies (a & 0x40E000)==0.
- R10: An abort sampled while busy ends the burst after the byte in progress, or before the first byte if it arrives during setup. The trailing 8 cycles still follow. An abort on the final byte's last cycle leaves the burst length unchanged. An abort while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a burst (taken when idle) |
| abort | input | 1 | Stop at the next byte boundary |
| cfg_dir | input | 1 | 0: A to B, 1: B to A |
| cfg_mode | input | 3 | B offset pattern |
| cfg_boff | input | B_W | B window base offset |
| cfg_bank | input | BANK_W | A bank |
| cfg_ofs | input | OFS_W | A start offset |
| cfg_fixed | input | 1 | Hold A offset |
| cfg_reverse | input | 1 | Decrement A offset |
| cfg_count | input | CNT_W | Byte count, 0 = 2^CNT_W |
| busy | output | 1 | Burst in progress |
| a_addr | output | BANK_W+OFS_W | A address |
| a_rd | output | 1 | A read strobe |
| a_wr | output | 1 | A write strobe |
| a_wdata | output | D_W | A write data |
| a_rdata | input | D_W | A read data |
| b_addr | output | B_W | B window offset |
| b_rd | output | 1 | B read strobe |
| b_wr | output | 1 | B write strobe |
| b_wdata | output | D_W | B write data |
| b_rdata | input | D_W | B read data |

## Verification
Two events can coincide with the end of a byte slot: an abort, and the byte counter reaching its last byte. The bench raises abort in exactly the last cycle of the final byte and expects the normal burst length and one trailing period, with no extra or missing bytes. The second coincidence is a posted write draining in the same slot that carries the next read. Every access is popped from a scoreboard that holds the access kind, address, data and exact cycle, so a late drain, a dropped drain or a duplicated drain shows up as a mismatch.

// File: rtl/bdma_pkg.sv
// Shared types for the burst byte-mover channel.
// Assumes an eight-clock byte slot, so the phase counter is three bits wide.
package bdma_pkg;
    localparam int PH_W = 3;
    typedef enum logic [1:0] {S_IDLE, S_SETUP, S_XFER, S_TAIL} seq_state_t;
endpackage

// File: rtl/bdma_boff_gen.sv
// B-window offset generator: adds the mode-dependent adjustment, taken from
// the 2-bit byte index, to the base offset. Purely combinational. The sum
// wraps inside the window.
module bdma_boff_gen #(
    parameter int B_W = 8
) (
    input  logic [2:0]     mode,
    input  logic [1:0]     idx,
    input  logic [B_W-1:0] base,
    output logic [B_W-1:0] off
);
    logic [1:0] adj;

    // Pick the per-byte adjustment for the configured mode.
    always_comb begin
        unique case (mode)
            3'd1, 3'd5: adj = {1'b0, idx[0]};
            3'd3, 3'd7: adj = {1'b0, idx[1]};
            3'd4:       adj = idx;
            default:    adj = 2'd0;
        endcase
        off = base + B_W'(adj);
    end
endmodule

// File: rtl/bdma_addr_filter.sv
// Access filter: flags A addresses that hit the control-register pages, and
// work-RAM port accesses on the B side whose A address is itself work RAM.
// Assumes a 24-bit A address and a B offset whose work-RAM port is 0x80.
module bdma_addr_filter #(
    parameter int A_W = 24,
    parameter int B_W = 8
) (
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b_off,
    output logic           a_ok,
    output logic           b_ok
);
    logic io_hit;
    logic a_is_wram;

    // Decode the forbidden A pages and the work-RAM clash.
    always_comb begin
        io_hit = ((a & A_W'(24'h40FF00)) == A_W'(24'h002100)) ||
                 ((a & A_W'(24'h40FE00)) == A_W'(24'h004000)) ||
                 ((a & A_W'(24'h40FFE0)) == A_W'(24'h004200)) ||
                 ((a & A_W'(24'h40FF80)) == A_W'(24'h004300));
        a_is_wram = (a[A_W-1:A_W-7] == 7'h3F) ||
                    ((a & A_W'(24'h40E000)) == '0);
        a_ok = !io_hit;
        b_ok = !((b_off == B_W'(8'h80)) && a_is_wram);
    end
endmodule

// File: rtl/bdma_seq.sv
// Burst sequencer: runs the setup, per-byte and trailing eight-clock periods,
// counts bytes and turns abort into a stop at the next byte boundary.
// Assumes start is a pulse. Start is ignored while a burst runs.
module bdma_seq
    import bdma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [CNT_W-1:0] count_init,
    output logic             busy,
    output logic             load,
    output logic             rd_slot,
    output logic             wr_slot,
    output logic             step
);
    localparam logic [PH_W-1:0] PH_LAST = '1;
    localparam logic [PH_W-1:0] PH_READ = PH_W'(3);

    seq_state_t       state;
    logic [PH_W-1:0]  ph;
    logic [CNT_W-1:0] cnt;
    logic             abort_pend;
    logic             stop_now;

    // Slot decode from state and phase.
    always_comb begin
        busy     = (state != S_IDLE);
        load     = (state == S_IDLE) && start;
        rd_slot  = (state == S_XFER) && (ph == PH_READ);
        wr_slot  = ((state == S_XFER) || (state == S_TAIL)) && (ph == '0);
        step     = (state == S_XFER) && (ph == PH_LAST);
        stop_now = abort || abort_pend;
    end

    // State, phase, byte count and pending-abort register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            ph         <= '0;
            cnt        <= '0;
            abort_pend <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    ph <= '0;
                    if (start) begin
                        state      <= S_SETUP;
                        cnt        <= count_init;
                        abort_pend <= 1'b0;
                    end
                end
                S_SETUP: begin
                    ph         <= ph + 1'b1;
                    abort_pend <= stop_now;
                    if (ph == PH_LAST) state <= stop_now ? S_TAIL : S_XFER;
                end
                S_XFER: begin
                    ph         <= ph + 1'b1;
                    abort_pend <= stop_now;
                    if (ph == PH_LAST) begin
                        cnt <= cnt - 1'b1;
                        if (stop_now || (cnt == CNT_W'(1))) state <= S_TAIL;
                    end
                end
                S_TAIL: begin
                    ph <= ph + 1'b1;
                    if (ph == PH_LAST) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2: an accepted start makes the channel busy on the next cycle.
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2: the byte count is untouched by start while a burst runs.
    p_restart_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !step) |=> (cnt == $past(cnt)));

    // R10: the channel goes idle only out of the trailing period.
    p_end_from_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_XFER) |=> (state != S_IDLE));
endmodule

// File: rtl/bdma_channel.sv
// Top of the burst byte-mover channel: holds the latched configuration, the
// A offset, the byte index and the one-entry posted write. It drives both
// bus sides from the sequencer slots. Assumes the bus responders return
// read data combinationally in the read slot.
module bdma_channel #(
    parameter int D_W    = 8,
    parameter int B_W    = 8,
    parameter int BANK_W = 8,
    parameter int OFS_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    abort,
    input  logic                    cfg_dir,
    input  logic [2:0]              cfg_mode,
    input  logic [B_W-1:0]          cfg_boff,
    input  logic [BANK_W-1:0]       cfg_bank,
    input  logic [OFS_W-1:0]        cfg_ofs,
    input  logic                    cfg_fixed,
    input  logic                    cfg_reverse,
    input  logic [CNT_W-1:0]        cfg_count,
    output logic                    busy,
    output logic [BANK_W+OFS_W-1:0] a_addr,
    output logic                    a_rd,
    output logic                    a_wr,
    output logic [D_W-1:0]          a_wdata,
    input  logic [D_W-1:0]          a_rdata,
    output logic [B_W-1:0]          b_addr,
    output logic                    b_rd,
    output logic                    b_wr,
    output logic [D_W-1:0]          b_wdata,
    input  logic [D_W-1:0]          b_rdata
);
    localparam int A_W = BANK_W + OFS_W;

    logic              load, rd_slot, wr_slot, step;
    logic              dir_q, fixed_q, rev_q;
    logic [2:0]        mode_q;
    logic [B_W-1:0]    boff_q;
    logic [BANK_W-1:0] bank_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [1:0]        idx_q;
    logic [A_W-1:0]    cur_a;
    logic [B_W-1:0]    cur_b;
    logic              a_ok, b_ok;
    logic [D_W-1:0]    rd_data;
    logic              pend_v, pend_to_a;
    logic [A_W-1:0]    pend_a;
    logic [B_W-1:0]    pend_b;
    logic [D_W-1:0]    pend_d;

    bdma_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .count_init(cfg_count), .busy(busy), .load(load),
        .rd_slot(rd_slot), .wr_slot(wr_slot), .step(step)
    );

    bdma_boff_gen #(.B_W(B_W)) u_boff (
        .mode(mode_q), .idx(idx_q), .base(boff_q), .off(cur_b)
    );

    bdma_addr_filter #(.A_W(A_W), .B_W(B_W)) u_filt (
        .a(cur_a), .b_off(cur_b), .a_ok(a_ok), .b_ok(b_ok)
    );

    // Current A address and the filtered read data for this byte.
    always_comb begin
        cur_a   = {bank_q, ofs_q};
        rd_data = dir_q ? (b_ok ? b_rdata : '0) : (a_ok ? a_rdata : '0);
    end

    // Bus strobes and address muxing between the read and the posted write.
    always_comb begin
        a_rd    = rd_slot && !dir_q && a_ok;
        b_rd    = rd_slot && dir_q && b_ok;
        a_wr    = wr_slot && pend_v && pend_to_a;
        b_wr    = wr_slot && pend_v && !pend_to_a;
        a_addr  = (wr_slot && pend_to_a) ? pend_a : cur_a;
        b_addr  = (wr_slot && !pend_to_a) ? pend_b : cur_b;
        a_wdata = pend_d;
        b_wdata = pend_d;
    end

    // Configuration latch, A offset stepping and byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0; fixed_q <= 1'b0; rev_q <= 1'b0;
            mode_q <= '0; boff_q <= '0; bank_q <= '0; ofs_q <= '0;
            idx_q <= '0;
        end else if (load) begin
            dir_q <= cfg_dir; fixed_q <= cfg_fixed; rev_q <= cfg_reverse;
            mode_q <= cfg_mode; boff_q <= cfg_boff; bank_q <= cfg_bank;
            ofs_q <= cfg_ofs; idx_q <= '0;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
            if (!fixed_q) ofs_q <= rev_q ? ofs_q - 1'b1 : ofs_q + 1'b1;
        end
    end

    // Posted write register: filled by the read slot, drained by the write slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0; pend_to_a <= 1'b0;
            pend_a <= '0; pend_b <= '0; pend_d <= '0;
        end else if (load || wr_slot) begin
            pend_v <= 1'b0;
        end else if (rd_slot) begin
            pend_v    <= dir_q ? a_ok : b_ok;
            pend_to_a <= dir_q;
            pend_a    <= cur_a;
            pend_b    <= cur_b;
            pend_d    <= rd_data;
        end
    end

    // R1: no bus activity while idle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(a_rd || a_wr || b_rd || b_wr));

    // R3: at most one strobe per cycle.
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({a_rd, a_wr, b_rd, b_wr}) <= 1);

    // R6: the bank stays fixed for the whole burst.
    p_bank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> (bank_q == $past(bank_q)));

    // R6: a fixed burst keeps its A offset across a byte step.
    p_fixed_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && fixed_q) |=> $stable(ofs_q));

    // R8: no A strobe reaches a control-register page.
    p_a_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd || a_wr) |->
            !(((a_addr & A_W'(24'h40FF00)) == A_W'(24'h002100)) ||
              ((a_addr & A_W'(24'h40FE00)) == A_W'(24'h004000)) ||
              ((a_addr & A_W'(24'h40FFE0)) == A_W'(24'h004200)) ||
              ((a_addr & A_W'(24'h40FF80)) == A_W'(24'h004300))));

    // R9: no work-RAM to work-RAM write through the B port.
    p_wram_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && (b_addr == B_W'(8'h80))) |->
            ((pend_a[A_W-1:A_W-7] != 7'h3F) &&
             ((pend_a & A_W'(24'h40E000)) != '0)));
endmodule

// File: tb/bdma_channel_bench.sv
// Scoreboard bench: the driver task queues every expected access with its
// cycle, and the monitor pops and compares each strobe as it appears.
module bdma_channel_bench;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, abort = 1'b0;
    logic        cfg_dir = 1'b0, cfg_fixed = 1'b0, cfg_reverse = 1'b0;
    logic [2:0]  cfg_mode = '0;
    logic [7:0]  cfg_boff = '0, cfg_bank = '0;
    logic [15:0] cfg_ofs = '0;
    logic [CW-1:0] cfg_count = '0;
    logic        busy, a_rd, a_wr, b_rd, b_wr;
    logic [23:0] a_addr;
    logic [7:0]  a_wdata, a_rdata, b_addr, b_wdata, b_rdata;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 A read, 1 A write, 2 B read, 3 B write
        logic [23:0] addr;
        logic [7:0]  data;
        int          cyc;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    bdma_channel #(.CNT_W(CW)) u_bdma_channel (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .cfg_dir(cfg_dir), .cfg_mode(cfg_mode), .cfg_boff(cfg_boff),
        .cfg_bank(cfg_bank), .cfg_ofs(cfg_ofs), .cfg_fixed(cfg_fixed),
        .cfg_reverse(cfg_reverse), .cfg_count(cfg_count), .busy(busy),
        .a_addr(a_addr), .a_rd(a_rd), .a_wr(a_wr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .b_addr(b_addr), .b_rd(b_rd), .b_wr(b_wr),
        .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    function automatic logic [7:0] mem_a(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] mem_b(logic [7:0] o);
        return o ^ 8'hC3;
    endfunction
    function automatic bit a_allowed(logic [23:0] a);
        return !(((a & 24'h40FF00) == 24'h002100) || ((a & 24'h40FE00) == 24'h004000) ||
                 ((a & 24'h40FFE0) == 24'h004200) || ((a & 24'h40FF80) == 24'h004300));
    endfunction
    function automatic bit in_wram(logic [23:0] a);
        return (a[23:17] == 7'h3F) || ((a & 24'h40E000) == 24'h0);
    endfunction
    function automatic logic [7:0] b_of(logic [2:0] m, int k, logic [7:0] base);
        logic [1:0] i = 2'(k);
        case (m)
            3'd1, 3'd5: return base + {7'd0, i[0]};
            3'd3, 3'd7: return base + {7'd0, i[1]};
            3'd4:       return base + {6'd0, i};
            default:    return base;
        endcase
    endfunction

    assign a_rdata = mem_a(a_addr);
    assign b_rdata = mem_b(b_addr);

    always @(posedge clk) begin
        if (start && !busy) cyc <= 1;
        else cyc <= cyc + 1;
    end

    task automatic fail(string tag, string what, int act, int exp);
        errors++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    task automatic see(int kind, logic [23:0] addr, logic [7:0] data);
        exp_t e;
        checks++;
        if (q.size() == 0) begin
            fail("R3", "unexpected access kind", kind, -1);
            return;
        end
        e = q.pop_front();
        if (kind != e.kind) fail(e.tag, "access kind", kind, e.kind);
        else if (addr != e.addr) fail(e.tag, "address", int'(addr), int'(e.addr));
        else if (cyc != e.cyc) fail(e.tag, "cycle", cyc, e.cyc);
        else if ((kind == 1 || kind == 3) && data != e.data)
            fail(e.tag, "data", int'(data), int'(e.data));
    endtask

    // Monitor: compare every strobe with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (a_rd) see(0, a_addr, 8'h0);
            if (a_wr) see(1, a_addr, a_wdata);
            if (b_rd) see(2, {16'h0, b_addr}, 8'h0);
            if (b_wr) see(3, {16'h0, b_addr}, b_wdata);
        end
    end

    task automatic push(int kind, logic [23:0] addr, logic [7:0] data, int c, string tag);
        exp_t e;
        e.kind = kind; e.addr = addr; e.data = data; e.cyc = c; e.tag = tag;
        q.push_back(e);
    endtask

    // Driver: queue the expected accesses, launch the burst, time it.
    task automatic run(string tag, bit dir, logic [2:0] mode, logic [7:0] boff,
                       logic [7:0] bank, logic [15:0] ofs, bit fixed, bit rev,
                       logic [CW-1:0] cnt, int nbytes, int abort_at, int poke_at);
        logic [15:0] o = ofs;
        int bc = 0;
        int j = 1;
        for (int k = 0; k < nbytes; k++) begin
            logic [23:0] a = {bank, o};
            logic [7:0]  b = b_of(mode, k, boff);
            bit aok = a_allowed(a);
            bit bok = !((b == 8'h80) && in_wram(a));
            logic [7:0] d;
            if (!dir) begin
                if (aok) push(0, a, 8'h0, 12 + 8 * k, tag);
                d = aok ? mem_a(a) : 8'h00;
                if (bok) push(3, {16'h0, b}, d, 17 + 8 * k, tag);
            end else begin
                if (bok) push(2, {16'h0, b}, 8'h0, 12 + 8 * k, tag);
                d = bok ? mem_b(b) : 8'h00;
                if (aok) push(1, a, d, 17 + 8 * k, tag);
            end
            if (!fixed) o = rev ? o - 16'd1 : o + 16'd1;
        end
        @(negedge clk);
        cfg_dir = dir; cfg_mode = mode; cfg_boff = boff; cfg_bank = bank;
        cfg_ofs = ofs; cfg_fixed = fixed; cfg_reverse = rev; cfg_count = cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) begin
            bc++;
            abort = (j == abort_at);
            if (j == poke_at) begin
                start = 1'b1; cfg_dir = ~cfg_dir; cfg_count = 1; cfg_ofs = 16'h1234;
            end else start = 1'b0;
            @(negedge clk);
            j++;
        end
        abort = 1'b0; start = 1'b0;
        checks++;
        if (bc != 16 + 8 * nbytes) fail(tag, "busy length", bc, 16 + 8 * nbytes);
        checks++;
        if (q.size() != 0) begin
            fail(tag, "missing accesses", 0, q.size());
            q.delete();
        end
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: idle and quiet during reset and right after it.
        repeat (3) @(negedge clk);
        checks++;
        if (busy || a_rd || a_wr || b_rd || b_wr) fail("R1", "reset outputs", 1, 0);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (busy || a_rd || a_wr || b_rd || b_wr) fail("R1", "post-reset outputs", 1, 0);

        // R4 R5 R3: A to B, alternating offset pattern, incrementing.
        run("R5", 0, 3'd1, 8'h18, 8'h01, 16'h8000, 0, 0, 5, 5, 0, 0);
        // R4 R5 R6: B to A, full four-step pattern, decrementing.
        run("R4", 1, 3'd4, 8'h20, 8'h7E, 16'h0101, 0, 1, 6, 6, 0, 0);
        // R5 R6: pair pattern with a fixed A offset; mode 7 wraps the window.
        run("R6", 0, 3'd3, 8'h30, 8'h02, 16'h9000, 1, 0, 4, 4, 0, 0);
        run("R5", 0, 3'd7, 8'hFF, 8'h03, 16'hFFFE, 0, 0, 4, 4, 0, 0);
        run("R5", 1, 3'd2, 8'h40, 8'h05, 16'hA000, 0, 0, 3, 3, 0, 0);
        // R8: crossing into a control page; bit 22 set escapes the filter.
        run("R8", 0, 3'd0, 8'h10, 8'h00, 16'h20FE, 0, 0, 4, 4, 0, 0);
        run("R8", 1, 3'd0, 8'h11, 8'h80, 16'h421E, 0, 0, 3, 3, 0, 0);
        run("R8", 1, 3'd0, 8'h12, 8'h40, 16'h437F, 0, 0, 2, 2, 0, 0);
        run("R8", 0, 3'd0, 8'h13, 8'h00, 16'h41FF, 0, 1, 2, 2, 0, 0);
        // R9: work-RAM port clashes in both directions.
        run("R9", 0, 3'd0, 8'h80, 8'h7F, 16'h1000, 0, 0, 2, 2, 0, 0);
        run("R9", 0, 3'd0, 8'h80, 8'h00, 16'h1FFF, 0, 0, 2, 2, 0, 0);
        run("R9", 1, 3'd0, 8'h80, 8'h7E, 16'h0010, 0, 0, 2, 2, 0, 0);
        // R7: zero count means the full counter range.
        run("R7", 0, 3'd4, 8'h00, 8'h01, 16'hC000, 0, 0, 0, 1 << CW, 0, 0);
        // R10: mid-burst abort, abort on the last byte's boundary, abort in setup.
        run("R10", 0, 3'd0, 8'h04, 8'h01, 16'h8100, 0, 0, 10, 2, 20, 0);
        run("R10", 1, 3'd1, 8'h06, 8'h01, 16'h8200, 0, 0, 3, 3, 32, 0);
        run("R10", 0, 3'd0, 8'h07, 8'h01, 16'h8300, 0, 0, 5, 0, 4, 0);
        // R10: abort while idle has no effect on the next burst.
        @(negedge clk); abort = 1'b1; @(negedge clk); abort = 1'b0;
        run("R10", 0, 3'd0, 8'h08, 8'h01, 16'h8400, 0, 0, 2, 2, 0, 0);
        // R2: restart with a new configuration mid-burst is ignored.
        run("R2", 0, 3'd1, 8'h09, 8'h01, 16'h8500, 0, 0, 3, 3, 0, 30);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule